// File: doc/BRIEF.md
# Bad Block Marker Scanner

This block decides whether one erase block of a flash array carries a factory bad-block marker. A request names the block, the number of pages per block and a marker rule. The scanner works out which two pages to inspect, asks a downstream page reader for the spare area of each one in turn, and consumes the spare bytes that come back as a stream. When it reaches a verdict it pulses `done` for one cycle, with `bad` or `err` alongside.

Two marker rules are supported. The full-scan rule (`req_mode` = 0) inspects the first and the last page of the block and treats any zero byte anywhere in either spare area as a bad marker. The legacy rule (`req_mode` = 1) inspects the first and the second page and looks only at spare byte 0 of each, where a zero means bad. Once a page shows a marker the scan stops and no further page is requested. The rest of that page's spare bytes are still drained, so the reader always sees its page finish cleanly. If the reader flags a failed read, the scan ends with an error in place of a verdict.

All three data interfaces use valid/ready. A transfer happens on a rising edge where both are high. The scanner never drops `rd_valid` or changes `rd_page` before `rd_ready`. The reader may insert idle cycles on the byte stream at will. The scanner accepts bytes only while a page is outstanding, and accepts at most one request at a time.

Top module: `bbm_scanner`

## Requirements
- R1: After reset, `done` is 0, `rd_valid` is 0, `sb_ready` is 0 and `req_ready` is 1.
- R2: The first page requested after a request is accepted is `req_block * req_ppb`.
- R3: With `req_mode` = 0, the second page requested is `req_block * req_ppb + req_ppb - 1`. A spare byte equal to 0x00 at any position of either page makes the verdict bad (`bad` = 1, `err` = 0).
- R4: With `req_mode` = 1, the second page requested is `req_block * req_ppb + 1`. Only the first byte of each page's spare stream is examined: a 0x00 there means bad, and zero bytes at any other position have no effect on the verdict.
- R5: When the first page shows a marker, no second page is requested. Each page is drained: exactly `spare_size` bytes are accepted for it, and `done` rises in the cycle after the last of them.
- R6: A byte beat with `sb_fail` = 1 is the final beat of its page. In the next cycle `done` = 1 with `err` = 1 and `bad` = 0, whatever the beat's data and any marker seen before.
- R7: If neither checked page shows a marker, the verdict is good (`bad` = 0, `err` = 0). `done` is high for exactly one cycle per request.
- R8: `rd_valid` stays high with `rd_page` unchanged until `rd_ready`. `req_ready` is high only while no scan is running. `sb_ready` is high only while a page is outstanding and never together with `rd_valid`.
- R9: `spare_size` (at least 1) is sampled when the request is accepted. Later changes do not alter the number of bytes accepted per page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Scan request offered |
| req_ready | output | 1 | Scanner idle and accepting a request |
| req_block | input | BLK_W | Erase block number |
| req_ppb | input | PPB_W | Pages per block, at least 1 |
| req_mode | input | 1 | 0 = full spare scan of first and last page, 1 = byte 0 of first and second page |
| spare_size | input | SPR_W | Spare bytes per page, at least 1, sampled at request acceptance |
| rd_valid | output | 1 | Spare-area read request valid |
| rd_ready | input | 1 | Reader takes the read request |
| rd_page | output | PAGE_W | Page number to read |
| sb_valid | input | 1 | Spare byte beat valid |
| sb_ready | output | 1 | Scanner accepts a spare byte |
| sb_data | input | 8 | Spare byte value |
| sb_fail | input | 1 | Read failed; this beat ends the page |
| done | output | 1 | One-cycle verdict strobe |
| bad | output | 1 | Block marked bad, valid with done |
| err | output | 1 | Scan ended by a read failure, valid with done |

## Verification
A single byte beat can carry both a read failure and a zero value, so marker detection and failure handling fall in the same cycle. The error must win. The bench provokes this with a directed case that presents `sb_fail` with data 0x00 on byte 0 of the first page, and with random cases that put zeros ahead of a failing beat. The judgement is that `done` comes with `err` = 1 and `bad` = 0. The scan's last-byte decision and a marker on that very byte also coincide. This is driven with a zero placed only in the final byte of the last page, and the verdict must be bad in the cycle after that byte.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RECV  = 2'd2
  } bbm_state_e;

  localparam logic MODE_FULL   = 1'b0;
  localparam logic MODE_LEGACY = 1'b1;
endpackage

// File: rtl/bbm_page_gen.sv
module bbm_page_gen #(
  parameter int BLK_W  = 10,
  parameter int PPB_W  = 9,
  parameter int PAGE_W = BLK_W + PPB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BLK_W-1:0]  blk,
  input  logic [PPB_W-1:0]  ppb,
  input  logic              legacy,
  input  logic              sel_second,
  output logic [PAGE_W-1:0] page
);
  logic [PAGE_W-1:0] base_q;
  logic [PAGE_W-1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
    end else if (load) begin
      base_q <= PAGE_W'(blk) * PAGE_W'(ppb);
      step_q <= legacy ? PAGE_W'(1) : (PAGE_W'(ppb) - PAGE_W'(1));
    end
  end

  assign page = sel_second ? (base_q + step_q) : base_q;
endmodule

// File: rtl/bbm_byte_judge.sv
module bbm_byte_judge #(
  parameter int SPR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SPR_W-1:0] size_in,
  input  logic             legacy_in,
  input  logic             page_start,
  input  logic             beat,
  input  logic [7:0]       data,
  output logic             last_beat,
  output logic             marker
);
  logic [SPR_W-1:0] size_q;
  logic [SPR_W-1:0] cnt_q;
  logic             legacy_q;
  logic             mark_q;
  logic             examine;
  logic             hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q   <= '0;
      legacy_q <= 1'b0;
    end else if (load) begin
      size_q   <= size_in;
      legacy_q <= legacy_in;
    end
  end

  assign examine   = !legacy_q || (cnt_q == '0);
  assign hit       = examine && (data == 8'h00);
  assign last_beat = (cnt_q == size_q - SPR_W'(1));
  assign marker    = mark_q || hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mark_q <= 1'b0;
    end else if (page_start) begin
      cnt_q  <= '0;
      mark_q <= 1'b0;
    end else if (beat) begin
      cnt_q  <= cnt_q + SPR_W'(1);
      mark_q <= mark_q || hit;
    end
  end
endmodule

// File: rtl/bbm_ctrl.sv
module bbm_ctrl
  import bbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rd_ready,
  input  logic sb_valid,
  input  logic sb_fail,
  input  logic last_beat,
  input  logic marker,
  output logic req_ready,
  output logic rd_valid,
  output logic sb_ready,
  output logic load,
  output logic page_start,
  output logic beat,
  output logic sel_second,
  output logic done,
  output logic bad,
  output logic err
);
  bbm_state_e state_q;
  logic       idx_q;
  logic       done_q;
  logic       bad_q;
  logic       err_q;

  assign req_ready  = (state_q == ST_IDLE);
  assign rd_valid   = (state_q == ST_ISSUE);
  assign sb_ready   = (state_q == ST_RECV);
  assign load       = req_ready && req_valid;
  assign page_start = rd_valid && rd_ready;
  assign beat       = sb_ready && sb_valid && !sb_fail;
  assign sel_second = idx_q;
  assign done       = done_q;
  assign bad        = bad_q;
  assign err        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= 1'b0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q <= ST_ISSUE;
            idx_q   <= 1'b0;
          end
        end
        ST_ISSUE: begin
          if (rd_ready) state_q <= ST_RECV;
        end
        ST_RECV: begin
          if (sb_valid) begin
            if (sb_fail) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              bad_q   <= 1'b0;
              err_q   <= 1'b1;
            end else if (last_beat) begin
              if (marker || idx_q) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                bad_q   <= marker;
                err_q   <= 1'b0;
              end else begin
                idx_q   <= 1'b1;
                state_q <= ST_ISSUE;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bbm_scanner.sv
module bbm_scanner #(
  parameter int BLK_W  = 10,
  parameter int PPB_W  = 9,
  parameter int SPR_W  = 8,
  localparam int PAGE_W = BLK_W + PPB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BLK_W-1:0]  req_block,
  input  logic [PPB_W-1:0]  req_ppb,
  input  logic              req_mode,
  input  logic [SPR_W-1:0]  spare_size,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [PAGE_W-1:0] rd_page,
  input  logic              sb_valid,
  output logic              sb_ready,
  input  logic [7:0]        sb_data,
  input  logic              sb_fail,
  output logic              done,
  output logic              bad,
  output logic              err
);
  logic load;
  logic page_start;
  logic beat;
  logic sel_second;
  logic last_beat;
  logic marker;

  bbm_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rd_ready   (rd_ready),
    .sb_valid   (sb_valid),
    .sb_fail    (sb_fail),
    .last_beat  (last_beat),
    .marker     (marker),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .sb_ready   (sb_ready),
    .load       (load),
    .page_start (page_start),
    .beat       (beat),
    .sel_second (sel_second),
    .done       (done),
    .bad        (bad),
    .err        (err)
  );

  bbm_page_gen #(
    .BLK_W  (BLK_W),
    .PPB_W  (PPB_W),
    .PAGE_W (PAGE_W)
  ) u_page (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .blk        (req_block),
    .ppb        (req_ppb),
    .legacy     (req_mode),
    .sel_second (sel_second),
    .page       (rd_page)
  );

  bbm_byte_judge #(
    .SPR_W (SPR_W)
  ) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .size_in    (spare_size),
    .legacy_in  (req_mode),
    .page_start (page_start),
    .beat       (beat),
    .data       (sb_data),
    .last_beat  (last_beat),
    .marker     (marker)
  );
endmodule

// File: rtl/bbm_scanner_checker.sv
module bbm_scanner_checker #(
  parameter int BLK_W  = 10,
  parameter int PPB_W  = 9,
  parameter int SPR_W  = 8,
  localparam int PAGE_W = BLK_W + PPB_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BLK_W-1:0]  req_block,
  input logic [PPB_W-1:0]  req_ppb,
  input logic              req_mode,
  input logic [SPR_W-1:0]  spare_size,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [PAGE_W-1:0] rd_page,
  input logic              sb_valid,
  input logic              sb_ready,
  input logic [7:0]        sb_data,
  input logic              sb_fail,
  input logic              done,
  input logic              bad,
  input logic              err
);
  logic [PAGE_W-1:0] exp_first_q;
  logic              first_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_first_q  <= '0;
      first_pend_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      exp_first_q  <= PAGE_W'(req_block) * PAGE_W'(req_ppb);
      first_pend_q <= 1'b1;
    end else if (rd_valid && rd_ready) begin
      first_pend_q <= 1'b0;
    end
  end

  assert_first_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && first_pend_q) |-> (rd_page == exp_first_q));

  assert_fail_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_valid && sb_ready && sb_fail) |=> (done && err && !bad));

  assert_verdict_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(bad && err));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_page)));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && sb_ready) && !(req_ready && (rd_valid || sb_ready)));
endmodule

bind bbm_scanner bbm_scanner_checker #(
  .BLK_W (BLK_W),
  .PPB_W (PPB_W),
  .SPR_W (SPR_W)
) u_chk (.*);

// File: tb/bbm_scanner_bench.sv
`timescale 1ns/1ps
module bbm_scanner_bench;
  localparam int BLK_W  = 10;
  localparam int PPB_W  = 9;
  localparam int SPR_W  = 8;
  localparam int PAGE_W = BLK_W + PPB_W;
  localparam int MAXS   = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [BLK_W-1:0]  req_block = '0;
  logic [PPB_W-1:0]  req_ppb = '0;
  logic              req_mode = 1'b0;
  logic [SPR_W-1:0]  spare_size = '0;
  logic              rd_valid;
  logic              rd_ready = 1'b0;
  logic [PAGE_W-1:0] rd_page;
  logic              sb_valid = 1'b0;
  logic              sb_ready;
  logic [7:0]        sb_data = '0;
  logic              sb_fail = 1'b0;
  logic              done;
  logic              bad;
  logic              err;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  int pdata [2][MAXS];
  int pfail [2];

  always #10 clk = ~clk;

  bbm_scanner #(.BLK_W(BLK_W), .PPB_W(PPB_W), .SPR_W(SPR_W)) u_bbm_scanner (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, cycles %0d expected below 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_page(input int blk, input int ppb, input int mode, input int idx);
    if (idx == 0) return blk * ppb;
    return (mode == 1) ? blk * ppb + 1 : blk * ppb + ppb - 1;
  endfunction

  function automatic int page_marker(input int p, input int mode, input int spare);
    if (mode == 1) return (pdata[p][0] == 0) ? 1 : 0;
    for (int i = 0; i < spare; i++) if (pdata[p][i] == 0) return 1;
    return 0;
  endfunction

  task automatic run_scan(input int blk, input int ppb, input int mode, input int spare,
                          input string tag);
    int np, e_bad, e_err, nb, early, notready, guard;
    np = 2; e_bad = 0; e_err = 0;
    for (int p = 0; p < 2; p++) begin
      if (pfail[p] >= 0) begin e_err = 1; np = p + 1; break; end
      if (page_marker(p, mode, spare) != 0) begin e_bad = 1; np = p + 1; break; end
    end
    @(negedge clk);
    req_valid = 1'b1; req_block = BLK_W'(blk); req_ppb = PPB_W'(ppb);
    req_mode = mode[0]; spare_size = SPR_W'(spare);
    guard = 0;
    while (!req_ready && guard < 20) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    spare_size = SPR_W'(1 + $urandom % MAXS);
    early = 0; notready = 0;
    for (int p = 0; p < np; p++) begin
      check({tag, " R8 read request valid"}, int'(rd_valid), 1);
      repeat ($urandom % 3) @(negedge clk);
      check({tag, (p == 0) ? " R2 first page" : ((mode == 1) ? " R4 second page" : " R3 last page")},
            int'(rd_page), exp_page(blk, ppb, mode, p));
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      nb = (pfail[p] >= 0) ? pfail[p] + 1 : spare;
      for (int b = 0; b < nb; b++) begin
        for (int g = 0; g < int'($urandom % 3); g++) begin
          sb_valid = 1'b0;
          @(negedge clk);
          if (done) early = 1;
        end
        if (!sb_ready) notready = 1;
        sb_valid = 1'b1;
        sb_data  = 8'(pdata[p][b]);
        sb_fail  = (b == pfail[p]);
        @(negedge clk);
        sb_valid = 1'b0; sb_fail = 1'b0;
        if (done && !(p == np - 1 && b == nb - 1)) early = 1;
      end
      if (p < np - 1) check({tag, " R5 no verdict between pages"}, int'(done), 0);
    end
    check({tag, " R5 R9 bytes drained before verdict"}, early, 0);
    check({tag, " R5 R9 bytes accepted while page open"}, notready, 0);
    check({tag, " R7 done strobe"}, int'(done), 1);
    check({tag, e_err ? " R6 err" : (e_bad ? " R3 R4 bad" : " R7 good")},
          int'({bad, err}), (e_bad << 1) | e_err);
    @(negedge clk);
    check({tag, " R7 done single cycle"}, int'(done), 0);
    check({tag, " R5 no further read"}, int'(rd_valid), 0);
    check({tag, " R8 idle accepts request"}, int'(req_ready), 1);
  endtask

  task automatic fill_clean(input int spare);
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < MAXS; i++) pdata[p][i] = 8'hFF;
      pfail[p] = -1;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 rd_valid after reset", int'(rd_valid), 0);
    check("R1 sb_ready after reset", int'(sb_ready), 0);
    check("R1 req_ready after reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    fill_clean(8);
    run_scan(5, 64, 0, 8, "dir good full");
    fill_clean(8);
    run_scan(7, 32, 1, 8, "dir good legacy");
    fill_clean(8); pdata[0][3] = 0; pdata[1][7] = 0;
    run_scan(9, 16, 1, 8, "dir R4 zero off byte0 ignored");
    fill_clean(8); pdata[1][7] = 0;
    run_scan(3, 128, 0, 8, "dir R3 zero last byte last page");
    fill_clean(8); pdata[0][0] = 0; pfail[0] = 0;
    run_scan(11, 8, 0, 8, "dir R6 fail with zero");
    fill_clean(8); pdata[0][1] = 0;
    run_scan(2, 4, 0, 8, "dir R5 early bad first page");
    fill_clean(5); pdata[1][0] = 0;
    run_scan(1023, 256, 1, 5, "dir R4 legacy second page bad");
    fill_clean(1);
    run_scan(40, 1, 0, 1, "dir ppb one");

    for (int t = 0; t < 60; t++) begin
      int sp, md;
      sp = 1 + $urandom % MAXS;
      md = $urandom % 2;
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < MAXS; i++)
          pdata[p][i] = ($urandom % 24 == 0) ? 0 : 1 + $urandom % 255;
        pfail[p] = ($urandom % 8 == 0) ? int'($urandom % sp) : -1;
      end
      run_scan($urandom % 1024, 1 + $urandom % 256, md, sp, "rnd");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule